// File: doc/BRIEF.md
# Programmable CRC Register Engine

This block computes a cyclic redundancy check over data written through a small register port. Software sets a polynomial, a starting value and a polynomial width (32, 16, 8 or 7 bits), pulses a reset through the control register, and then writes data as bytes, halfwords or words. Bytes are folded into the running value most significant bit first. There is no bit reflection and no final XOR. A read of the data register returns the running value.

A multi-byte write is split into bytes from the most significant byte down, so a bus word holds its bytes in big-endian order. This lets a 15-bit packet error code be computed as a left-aligned 16-bit CRC. In that case the polynomial register holds 0x8B32 and the start register holds twice the 15-bit seed. The result comes back shifted left by one, with bit 0 clear. Byte, halfword and mixed write sequences of the same byte stream give the same result.

Each data write goes into a single holding slot. The slot feeds a datapath that handles one byte per clock. The port inserts wait states only when the slot is still occupied. It also inserts wait states when a read or a reset must wait for all earlier data to be processed.

Top module: `prog_crc_unit`

## Requirements
- R1: After rst_ni is released, the data register reads 0xFFFFFFFF, the control register reads 0, the start register reads 0xFFFFFFFF and the polynomial register reads 0x04C11DB7.
- R2: Register index addr_i selects 0 = data, 1 = control, 2 = start value, 3 = polynomial. The start value and polynomial registers read back what was last written.
- R3: A control write with bit 0 set loads the running CRC with the start value masked to the selected width. Bit 0 is not stored and always reads as 0.
- R4: Control bits [4:3] select the width: 00 = 32, 01 = 16, 10 = 8, 11 = 7 bits. The data register reads the running CRC masked to that width.
- R5: Each byte is processed MSB first. Per bit, the feedback is the top CRC bit XOR the data bit; the CRC shifts left, and the polynomial is XORed in when the feedback is 1. There is no reflection and no final XOR. With polynomial 0x8B32, start value 0x20 and 16-bit width, the bytes A5 02 03 04 05 FE give 0xEA4C.
- R6: size_i selects the write size: 0 = byte in wdata_i[7:0], 1 = halfword in wdata_i[15:0], 2 = word. Bytes are processed from the most significant byte down, so a word followed by a halfword, or three halfwords, give the same result as six byte writes.
- R7: A data write to an empty holding slot is accepted in its first cycle, with no wait state.
- R8: A data write that arrives while the holding slot is occupied is held with ready_o low until the slot empties.
- R9: A data register read waits until the slot is empty and the datapath is idle. The value returned includes every byte written before the read.
- R10: A control write with the reset bit set waits until all pending data has been processed before it is applied.
- R11: The datapath consumes one byte per clock. A read issued in the cycle after a write of N bytes to an idle unit is held for N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register index |
| size_i | input | 2 | Data write size (0 byte, 1 halfword, 2 word) |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Transfer completes on a clock edge where req_i and ready_o are both high |
| rdata_o | output | 32 | Read data, valid while ready_o is high |

## Verification
The assertions check, on every cycle, four properties. The holding slot keeps its contents until the datapath takes them. The datapath counts down one byte per cycle. The running value does not move while the datapath is idle and no reset is applied. A reset is only applied when nothing is pending. The bench scenarios are the only place the numeric results are shown: the 0xEA4C packet code reached through three different write groupings, the masking of the 8-bit and 7-bit widths, and the exact wait-state counts for reads and resets that follow writes of different sizes.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef enum logic [1:0] {PW32 = 2'd0, PW16 = 2'd1, PW8 = 2'd2, PW7 = 2'd3} poly_w_e;
  typedef enum logic [1:0] {XS_BYTE = 2'd0, XS_HALF = 2'd1, XS_WORD = 2'd2} xfer_sz_e;

  localparam int unsigned DW = 32;
  localparam int unsigned CW = 3;

  function automatic int unsigned width_of(poly_w_e w);
    case (w)
      PW16:    return 16;
      PW8:     return 8;
      PW7:     return 7;
      default: return 32;
    endcase
  endfunction

  function automatic logic [DW-1:0] mask_of(poly_w_e w);
    case (w)
      PW16:    return 32'h0000_FFFF;
      PW8:     return 32'h0000_00FF;
      PW7:     return 32'h0000_007F;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] crc_byte(logic [DW-1:0] crc, logic [DW-1:0] poly,
                                              poly_w_e w, logic [7:0] b);
    logic [DW-1:0] c;
    logic fb;
    int unsigned top;
    c = crc;
    top = width_of(w) - 1;
    for (int i = 7; i >= 0; i--) begin
      fb = c[top[4:0]] ^ b[i];
      c = c << 1;
      if (fb) c = c ^ poly;
    end
    return c & mask_of(w);
  endfunction
endpackage

// File: rtl/crc_in_buf.sv
module crc_in_buf
  import crc_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned CNT_W  = CW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      cnt_o   <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      cnt_o   <= cnt_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_slot_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o) && $stable(cnt_o)));
  assert_push_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> valid_o);
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned CNT_W  = CW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] seed_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] poly_i,
  input  poly_w_e           width_i,
  output logic              take_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] crc_o
);
  logic [DATA_W-1:0] shreg_q;

  assign take_o = (cnt_o <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_o   <= '1;
      shreg_q <= '0;
      cnt_o   <= '0;
    end else if (clear_i) begin
      crc_o <= seed_i;
      cnt_o <= '0;
    end else begin
      if (cnt_o != '0) crc_o <= crc_byte(crc_o, poly_i, width_i, shreg_q[DATA_W-1 -: 8]);
      if (cnt_o > CNT_W'(1)) begin
        shreg_q <= shreg_q << 8;
        cnt_o   <= cnt_o - CNT_W'(1);
      end else if (load_i) begin
        shreg_q <= data_i;
        cnt_o   <= cnt_i;
      end else begin
        cnt_o <= '0;
      end
    end
  end

  assert_byte_rate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o > CNT_W'(1) && !clear_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !clear_i) |=> $stable(crc_o));
endmodule

// File: rtl/prog_crc_unit.sv
module prog_crc_unit
  import crc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic        ready_o,
  output logic [31:0] rdata_o
);
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_INIT = 2'd2, A_POLY = 2'd3;

  poly_w_e       width_q;
  logic [DW-1:0] init_q, poly_q;
  logic          buf_valid, take, idle, acc, do_reset, push;
  logic [DW-1:0] buf_data, eng_crc, push_data;
  logic [CW-1:0] buf_cnt, eng_cnt, push_cnt;

  assign idle = !buf_valid && (eng_cnt == '0);

  always_comb begin
    ready_o = 1'b1;
    if (req_i) begin
      if (addr_i == A_DATA) ready_o = we_i ? !buf_valid : idle;
      else if (addr_i == A_CTRL && we_i && wdata_i[0]) ready_o = idle;
    end
  end

  assign acc      = req_i && ready_o;
  assign push     = acc && we_i && (addr_i == A_DATA);
  assign do_reset = acc && we_i && (addr_i == A_CTRL) && wdata_i[0];

  always_comb begin
    case (xfer_sz_e'(size_i))
      XS_BYTE: begin push_data = {wdata_i[7:0], 24'b0};  push_cnt = CW'(1); end
      XS_HALF: begin push_data = {wdata_i[15:0], 16'b0}; push_cnt = CW'(2); end
      default: begin push_data = wdata_i;                push_cnt = CW'(4); end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= PW32;
      init_q  <= '1;
      poly_q  <= 32'h04C1_1DB7;
    end else if (acc && we_i) begin
      case (addr_i)
        A_CTRL:  width_q <= poly_w_e'(wdata_i[4:3]);
        A_INIT:  init_q  <= wdata_i;
        A_POLY:  poly_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  crc_in_buf u_buf (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (push_data),
    .cnt_i  (push_cnt),
    .pop_i  (buf_valid && take),
    .valid_o(buf_valid),
    .data_o (buf_data),
    .cnt_o  (buf_cnt)
  );

  crc_byte_engine u_eng (
    .clk_i, .rst_ni,
    .clear_i(do_reset),
    .seed_i (init_q & mask_of(poly_w_e'(wdata_i[4:3]))),
    .load_i (buf_valid),
    .data_i (buf_data),
    .cnt_i  (buf_cnt),
    .poly_i (poly_q),
    .width_i(width_q),
    .take_o (take),
    .cnt_o  (eng_cnt),
    .crc_o  (eng_crc)
  );

  always_comb begin
    case (addr_i)
      A_DATA:  rdata_o = eng_crc & mask_of(width_q);
      A_CTRL:  rdata_o = {27'b0, width_q, 3'b0};
      A_INIT:  rdata_o = init_q;
      default: rdata_o = poly_q;
    endcase
  end

  assert_reset_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_reset |-> (!buf_valid && eng_cnt == '0));
  assert_full_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_DATA && buf_valid) |-> !push);
endmodule

// File: tb/prog_crc_unit_test.sv
module prog_crc_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0, size = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  int errors = 0, checks = 0, cycles = 0;

  // reference state
  int          m_w = 32;
  logic [31:0] m_crc = 32'hFFFF_FFFF, m_init = 32'hFFFF_FFFF, m_poly = 32'h04C1_1DB7;

  always #2 clk = ~clk;

  prog_crc_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] mmask(int w);
    longint unsigned one = 1;
    return 32'(((one << w) - 1));
  endfunction

  function automatic logic [31:0] mstep(int w, logic [31:0] p, logic [31:0] c, logic [7:0] b);
    longint unsigned r = c;
    longint unsigned m = mmask(w);
    for (int i = 7; i >= 0; i--) begin
      bit t = bit'((r >> (w - 1)) & 1) ^ b[i];
      r = (r << 1) & m;
      if (t) r = r ^ (p & m);
    end
    return 32'(r);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // call at a negedge; returns at the next negedge after acceptance
  task automatic xfer(input logic w, input logic [1:0] a, input logic [1:0] s,
                      input logic [31:0] d, output logic [31:0] rd, output int stalls);
    req = 1'b1; we = w; addr = a; size = s; wdata = d; stalls = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1; stalls++;
    end
    rd = rdata;
    @(negedge clk);
    req = 1'b0;
    if (w) begin
      if (a == 2'd1) begin
        m_w = (d[4:3] == 2'd0) ? 32 : (d[4:3] == 2'd1) ? 16 : (d[4:3] == 2'd2) ? 8 : 7;
        if (d[0]) m_crc = m_init & mmask(m_w);
      end else if (a == 2'd2) m_init = d;
      else if (a == 2'd3) m_poly = d;
      else begin
        int n = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
        for (int k = n - 1; k >= 0; k--) m_crc = mstep(m_w, m_poly, m_crc, d[8*k +: 8]);
      end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] s, input logic [31:0] d, output int st);
    logic [31:0] dummy;
    xfer(1'b1, a, s, d, dummy, st);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v, output int st);
    xfer(1'b0, a, 2'd0, 32'd0, v, st);
  endtask

  initial begin
    logic [31:0] v;
    int st, st2;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    rd(2'd0, v, st); chk("R1 data", v, 32'hFFFF_FFFF);
    rd(2'd1, v, st); chk("R1 ctrl", v, 32'h0);
    rd(2'd2, v, st); chk("R1 init", v, 32'hFFFF_FFFF);
    rd(2'd3, v, st); chk("R1 poly", v, 32'h04C1_1DB7);

    wr(2'd2, 2'd2, 32'h20, st);
    wr(2'd3, 2'd2, 32'h8B32, st);
    rd(2'd2, v, st); chk("R2 init", v, 32'h20);
    rd(2'd3, v, st); chk("R2 poly", v, 32'h8B32);

    wr(2'd1, 2'd2, 32'h9, st);
    rd(2'd1, v, st); chk("R3 R4 ctrl", v, 32'h8);
    rd(2'd0, v, st); chk("R3 seed", v, 32'h20);

    // six single bytes, back to back
    wr(2'd0, 2'd0, 32'hA5, st);  chk("R7 no stall", st, 0);
    wr(2'd0, 2'd0, 32'h02, st2); chk("R8 stalled", 32'(st2 > 0), 32'd1);
    wr(2'd0, 2'd0, 32'h03, st);
    wr(2'd0, 2'd0, 32'h04, st);
    wr(2'd0, 2'd0, 32'h05, st);
    wr(2'd0, 2'd0, 32'hFE, st);
    rd(2'd0, v, st); chk("R5 bytes", v, 32'hEA4C); chk("R9 model", v, m_crc);

    wr(2'd1, 2'd2, 32'h9, st);
    wr(2'd0, 2'd1, 32'hA502, st);
    wr(2'd0, 2'd1, 32'h0304, st);
    wr(2'd0, 2'd1, 32'h05FE, st);
    rd(2'd0, v, st); chk("R6 halves", v, 32'hEA4C);

    wr(2'd1, 2'd2, 32'h9, st);
    wr(2'd0, 2'd2, 32'hA502_0304, st);
    wr(2'd0, 2'd1, 32'h05FE, st);
    rd(2'd0, v, st); chk("R6 word+half", v, 32'hEA4C);

    // read latency per size
    wr(2'd1, 2'd2, 32'h9, st);
    wr(2'd0, 2'd2, 32'h1122_3344, st); rd(2'd0, v, st);
    chk("R11 word stall", st, 5); chk("R9 word value", v, m_crc);
    wr(2'd0, 2'd1, 32'h5566, st); rd(2'd0, v, st);
    chk("R11 half stall", st, 3); chk("R9 half value", v, m_crc);
    wr(2'd0, 2'd0, 32'h77, st); rd(2'd0, v, st);
    chk("R11 byte stall", st, 2); chk("R9 byte value", v, m_crc);

    // reset waits for pending data
    wr(2'd0, 2'd2, 32'hDEAD_BEEF, st);
    wr(2'd1, 2'd2, 32'h9, st); chk("R10 reset stall", st, 5);
    rd(2'd0, v, st); chk("R10 after reset", v, 32'h20);

    // 8-bit width
    wr(2'd2, 2'd2, 32'hFFFF_FFFF, st);
    wr(2'd3, 2'd2, 32'h07, st);
    wr(2'd1, 2'd2, 32'h11, st);
    rd(2'd0, v, st); chk("R4 8b seed", v, 32'hFF);
    wr(2'd0, 2'd2, 32'h3132_3334, st);
    rd(2'd0, v, st); chk("R4 8b", v, m_crc);

    // 7-bit width
    wr(2'd2, 2'd2, 32'h0, st);
    wr(2'd3, 2'd2, 32'h09, st);
    wr(2'd1, 2'd2, 32'h19, st);
    wr(2'd0, 2'd1, 32'hC3A7, st);
    rd(2'd0, v, st); chk("R4 7b", v, m_crc);
    chk("R4 7b range", 32'(v > 32'h7F), 32'd0);

    // 32-bit width
    wr(2'd2, 2'd2, 32'hFFFF_FFFF, st);
    wr(2'd3, 2'd2, 32'h04C1_1DB7, st);
    wr(2'd1, 2'd2, 32'h1, st);
    wr(2'd0, 2'd2, 32'h3132_3334, st);
    wr(2'd0, 2'd0, 32'h35, st);
    rd(2'd0, v, st); chk("R5 32b", v, m_crc);
    rd(2'd1, v, st); chk("R3 self-clear", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule